// File: doc/BRIEF.md
# Page Translation Buffer with Per-Page Attributes

This block turns a virtual page number and the identifier of the running process into a physical page number. With each translation it also returns the access attributes stored with the page: a cache policy, a flag for pages that sit on a half-width (16-bit) bus, and a parity-check enable. The entries sit in two independent banks. Each bank is two-way set-associative, and each set carries one replacement bit. A lookup is purely combinational on the stored contents, so the result is available in the same cycle as the request.

Software fills the buffer through a synchronous write port. On a miss, the block reports which way the replacement bit of each bank points at for the looked-up set. The refill handler picks a bank and writes that way. An entry marked global matches for every process. When translation is switched off, the block passes the page number straight through and returns default attributes.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, so any translated lookup misses (`hit`=0, `ppn_out`=0, all attributes 0), and every replacement bit points at way 0.
- R2: With `xlat_en`=1, an entry hits when it is valid, its stored tag equals `lk_vpn[19:4]` in the set `lk_vpn[3:0]`, and its stored PID equals `cur_pid`. `ppn_out` then gives the entry's physical page, and `hit_bank`/`hit_way` name it. On a miss, `ppn_out`, `hit_bank` and `hit_way` are 0.
- R3: An entry whose global bit is set hits whatever `cur_pid` is.
- R4: `policy` returns the hitting entry's 2-bit field: 00 copy-back, 01 write-through, 10 reserved, 11 non-cacheable. `attr_err` is 1 exactly when a hitting entry holds 10.
- R5: `noncache` is 1 on a hit whose policy is 11 or whose narrow flag is set, whatever the policy field holds.
- R6: `narrow` mirrors the hitting entry's narrow flag. `split_xfer` is 1 when that flag is set and `lk_word32`=1, meaning one 32-bit access becomes two 16-bit transfers.
- R7: `par_chk` mirrors the hitting entry's parity-enable bit. `par_odd` equals the global `par_odd_cfg` input while `par_chk` is 1, and is 0 otherwise.
- R8: With `xlat_en`=0, `hit`=1, `ppn_out`=`lk_vpn`, `policy`=00 (copy-back), and `noncache`, `narrow`, `split_xfer`, `par_chk`, `par_odd`, `attr_err`, `multi_hit`, `hit_bank` and `hit_way` are 0. No replacement bit changes.
- R9: `repl_way[b]` shows bank b's replacement bit for the looked-up set. A hit with `lk_valid`=1 sets the winning bank's bit to the way it did not hit and leaves the other bank alone.
- R10: A translated miss with `lk_valid`=1 toggles the replacement bit of that set in both banks.
- R11: A write (`wr_en`=1) to bank `wr_bank`, set `wr_set`, way `wr_way` becomes visible from the next clock edge. A lookup in the same cycle still sees the old contents. Writes never change replacement bits.
- R12: When several entries hit, the winner is chosen in the order bank 0 way 0, bank 0 way 1, bank 1 way 0, bank 1 way 1, and `multi_hit`=1.
- R13: With `lk_valid`=0, lookup outputs are still produced, but no replacement bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xlat_en | input | 1 | Translation enable; 0 passes addresses through |
| lk_valid | input | 1 | Lookup is real and may update replacement state |
| lk_vpn | input | 20 | Virtual page number to look up |
| cur_pid | input | 8 | Identifier of the running process |
| lk_word32 | input | 1 | Access is a 32-bit data object |
| par_odd_cfg | input | 1 | Global parity sense, 1 = odd |
| wr_en | input | 1 | Write one entry |
| wr_bank | input | 1 | Bank to write |
| wr_set | input | 4 | Set to write |
| wr_way | input | 1 | Way to write |
| wr_tag | input | 16 | Upper virtual page bits to store |
| wr_pid | input | 8 | Process identifier to store |
| wr_vld | input | 1 | Valid bit to store |
| wr_glb | input | 1 | Global bit to store |
| wr_ppn | input | 20 | Physical page to store |
| wr_policy | input | 2 | Cache policy field to store |
| wr_narrow | input | 1 | Half-width bus flag to store |
| wr_par_en | input | 1 | Parity-check enable to store |
| hit | output | 1 | Translation found (always 1 when disabled) |
| multi_hit | output | 1 | More than one entry matched |
| hit_bank | output | 1 | Bank of the winning entry |
| hit_way | output | 1 | Way of the winning entry |
| ppn_out | output | 20 | Physical page number |
| policy | output | 2 | Cache policy of the page |
| noncache | output | 1 | Access must bypass the cache |
| narrow | output | 1 | Page lies on the 16-bit bus |
| split_xfer | output | 1 | 32-bit access needs two 16-bit transfers |
| par_chk | output | 1 | Parity checking on for this access |
| par_odd | output | 1 | Parity sense to check with |
| attr_err | output | 1 | Hitting entry holds the reserved policy |
| repl_way | output | 2 | Replacement way per bank for the looked-up set |

## Verification
The bench attacks the cases where a plausible design slips. A global entry looked up under a foreign PID would miss if the PID compare were not bypassed. A narrow page marked copy-back would come out cacheable if the narrow flag did not override the policy. A write and a lookup to the same set in one cycle would show the new entry too early if the write were forwarded. Duplicate entries spread over both banks would return the wrong page if the priority order were wrong. The bench also checks the replacement bits after hits, misses and idle cycles: a design that moved only one bank on a miss, or updated on `lk_valid`=0 or with translation off, would report a different `repl_way` on the next lookup of that set.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef enum logic [1:0] {
      POL_COPYBACK = 2'b00,
      POL_WRTHRU   = 2'b01,
      POL_RSVD     = 2'b10,
      POL_NOCACHE  = 2'b11
   } pol_e;
endpackage

// File: rtl/tlb_bank.sv
module tlb_bank
   import tlb_pkg::*;
#(
   parameter int VPN_W = 20,
   parameter int PPN_W = 20,
   parameter int PID_W = 8,
   parameter int SETS  = 16,
   parameter int WAYS  = 2,
   localparam int IDX_W = $clog2(SETS),
   localparam int TAG_W = VPN_W - IDX_W,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_set,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic [PID_W-1:0] lk_pid,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_set,
   input  logic [WAY_W-1:0] wr_way,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PID_W-1:0] wr_pid,
   input  logic             wr_vld,
   input  logic             wr_glb,
   input  logic [PPN_W-1:0] wr_ppn,
   input  pol_e             wr_pol,
   input  logic             wr_nar,
   input  logic             wr_par,
   input  logic             lru_we,
   input  logic [WAY_W-1:0] lru_wval,
   output logic             bk_hit,
   output logic             bk_multi,
   output logic [WAY_W-1:0] bk_way,
   output logic [PPN_W-1:0] bk_ppn,
   output pol_e             bk_pol,
   output logic             bk_nar,
   output logic             bk_par,
   output logic [WAY_W-1:0] bk_lru
);

   if (WAYS != 2) begin : g_bad_ways
      $error("tlb_bank: one replacement bit per set needs WAYS == 2");
   end
   if ((1 << IDX_W) != SETS) begin : g_bad_sets
      $error("tlb_bank: SETS must be a power of two");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("tlb_bank: VPN_W must exceed the index width");
   end

   logic [WAYS-1:0]  vld_q [SETS];
   logic [TAG_W-1:0] tag_q [SETS][WAYS];
   logic [PID_W-1:0] pid_q [SETS][WAYS];
   logic             glb_q [SETS][WAYS];
   logic [PPN_W-1:0] ppn_q [SETS][WAYS];
   pol_e             pol_q [SETS][WAYS];
   logic             nar_q [SETS][WAYS];
   logic             par_q [SETS][WAYS];
   logic [WAY_W-1:0] lru_q [SETS];
   logic [WAYS-1:0]  way_match;
   logic [WAY_W-1:0] win;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign way_match[w] = vld_q[lk_set][w]
                         && (tag_q[lk_set][w] == lk_tag)
                         && (glb_q[lk_set][w] || (pid_q[lk_set][w] == lk_pid));
   end

   always_comb begin
      win = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (way_match[w]) win = w[WAY_W-1:0];
      end
   end

   assign bk_hit   = |way_match;
   assign bk_multi = $countones(way_match) > 1;
   assign bk_way   = win;
   assign bk_ppn   = ppn_q[lk_set][win];
   assign bk_pol   = pol_q[lk_set][win];
   assign bk_nar   = nar_q[lk_set][win];
   assign bk_par   = par_q[lk_set][win];
   assign bk_lru   = lru_q[lk_set];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else if (wr_en) begin
         vld_q[wr_set][wr_way] <= wr_vld;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_set][wr_way] <= wr_tag;
         pid_q[wr_set][wr_way] <= wr_pid;
         glb_q[wr_set][wr_way] <= wr_glb;
         ppn_q[wr_set][wr_way] <= wr_ppn;
         pol_q[wr_set][wr_way] <= wr_pol;
         nar_q[wr_set][wr_way] <= wr_nar;
         par_q[wr_set][wr_way] <= wr_par;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
      end else if (lru_we) begin
         lru_q[lk_set] <= lru_wval;
      end
   end

   // R11: a written valid bit is in place after the edge
   a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> vld_q[$past(wr_set)][$past(wr_way)] == $past(wr_vld));

   // R9: replacement bit takes the value requested by the lookup
   a_r9_lru_follows: assert property (@(posedge clk) disable iff (!rst_n)
      lru_we |=> lru_q[$past(lk_set)] == $past(lru_wval));

   // R12: a multiple match is always a match
   a_r12_multi_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
      bk_multi |-> bk_hit);

endmodule

// File: rtl/tlb_attr.sv
module tlb_attr
   import tlb_pkg::*;
(
   input  logic       xlat_en,
   input  logic       hit_any,
   input  pol_e       pol,
   input  logic       nar,
   input  logic       par,
   input  logic       word32,
   input  logic       odd_cfg,
   output logic [1:0] policy,
   output logic       noncache,
   output logic       narrow,
   output logic       split_xfer,
   output logic       par_chk,
   output logic       par_odd,
   output logic       attr_err
);
   logic use_entry;

   assign use_entry  = xlat_en && hit_any;
   assign policy     = use_entry ? pol : POL_COPYBACK;
   assign noncache   = use_entry && ((pol == POL_NOCACHE) || nar);
   assign narrow     = use_entry && nar;
   assign split_xfer = narrow && word32;
   assign par_chk    = use_entry && par;
   assign par_odd    = par_chk && odd_cfg;
   assign attr_err   = use_entry && (pol == POL_RSVD);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
   import tlb_pkg::*;
#(
   parameter int VPN_W = 20,
   parameter int PPN_W = 20,
   parameter int PID_W = 8,
   parameter int SETS  = 16,
   parameter int WAYS  = 2,
   parameter int BANKS = 2,
   localparam int IDX_W = $clog2(SETS),
   localparam int TAG_W = VPN_W - IDX_W,
   localparam int WAY_W = $clog2(WAYS),
   localparam int BK_W  = $clog2(BANKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xlat_en,
   input  logic             lk_valid,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic [PID_W-1:0] cur_pid,
   input  logic             lk_word32,
   input  logic             par_odd_cfg,
   input  logic             wr_en,
   input  logic [BK_W-1:0]  wr_bank,
   input  logic [IDX_W-1:0] wr_set,
   input  logic [WAY_W-1:0] wr_way,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PID_W-1:0] wr_pid,
   input  logic             wr_vld,
   input  logic             wr_glb,
   input  logic [PPN_W-1:0] wr_ppn,
   input  logic [1:0]       wr_policy,
   input  logic             wr_narrow,
   input  logic             wr_par_en,
   output logic             hit,
   output logic             multi_hit,
   output logic [BK_W-1:0]  hit_bank,
   output logic [WAY_W-1:0] hit_way,
   output logic [PPN_W-1:0] ppn_out,
   output logic [1:0]       policy,
   output logic             noncache,
   output logic             narrow,
   output logic             split_xfer,
   output logic             par_chk,
   output logic             par_odd,
   output logic             attr_err,
   output logic [BANKS-1:0] repl_way
);

   if (PPN_W != VPN_W) begin : g_bad_ppn
      $error("tlb_xlate: pass-through needs PPN_W == VPN_W");
   end
   if (BANKS < 2 || (1 << BK_W) != BANKS) begin : g_bad_banks
      $error("tlb_xlate: BANKS must be a power of two, at least 2");
   end

   logic [IDX_W-1:0] set_idx;
   logic [TAG_W-1:0] tag_cmp;
   logic             look, any;
   logic [BK_W-1:0]  win_b;
   logic [WAY_W-1:0] win_way;

   logic [BANKS-1:0] bk_hit, bk_multi, lru_we;
   logic [WAY_W-1:0] bk_way   [BANKS];
   logic [WAY_W-1:0] bk_lru   [BANKS];
   logic [WAY_W-1:0] lru_wval [BANKS];
   logic [PPN_W-1:0] bk_ppn   [BANKS];
   pol_e             bk_pol   [BANKS];
   logic             bk_nar   [BANKS];
   logic             bk_par   [BANKS];

   assign set_idx = lk_vpn[IDX_W-1:0];
   assign tag_cmp = lk_vpn[VPN_W-1:IDX_W];
   assign look    = lk_valid && xlat_en;
   assign any     = |bk_hit;

   always_comb begin
      win_b = '0;
      for (int b = BANKS - 1; b >= 0; b--) begin
         if (bk_hit[b]) win_b = b[BK_W-1:0];
      end
   end
   assign win_way = bk_way[win_b];

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      assign lru_we[b]   = look && (!any || (win_b == BK_W'(b)));
      assign lru_wval[b] = any ? ~win_way : ~bk_lru[b];
      assign repl_way[b] = bk_lru[b];

      tlb_bank #(
         .VPN_W(VPN_W), .PPN_W(PPN_W), .PID_W(PID_W),
         .SETS(SETS), .WAYS(WAYS)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .lk_set   (set_idx),
         .lk_tag   (tag_cmp),
         .lk_pid   (cur_pid),
         .wr_en    (wr_en && (wr_bank == BK_W'(b))),
         .wr_set   (wr_set),
         .wr_way   (wr_way),
         .wr_tag   (wr_tag),
         .wr_pid   (wr_pid),
         .wr_vld   (wr_vld),
         .wr_glb   (wr_glb),
         .wr_ppn   (wr_ppn),
         .wr_pol   (pol_e'(wr_policy)),
         .wr_nar   (wr_narrow),
         .wr_par   (wr_par_en),
         .lru_we   (lru_we[b]),
         .lru_wval (lru_wval[b]),
         .bk_hit   (bk_hit[b]),
         .bk_multi (bk_multi[b]),
         .bk_way   (bk_way[b]),
         .bk_ppn   (bk_ppn[b]),
         .bk_pol   (bk_pol[b]),
         .bk_nar   (bk_nar[b]),
         .bk_par   (bk_par[b]),
         .bk_lru   (bk_lru[b])
      );
   end

   assign hit       = xlat_en ? any : 1'b1;
   assign multi_hit = xlat_en && ((|bk_multi) || ($countones(bk_hit) > 1));
   assign hit_bank  = (xlat_en && any) ? win_b : '0;
   assign hit_way   = (xlat_en && any) ? win_way : '0;
   assign ppn_out   = !xlat_en ? lk_vpn : (any ? bk_ppn[win_b] : '0);

   tlb_attr u_attr (
      .xlat_en    (xlat_en),
      .hit_any    (any),
      .pol        (bk_pol[win_b]),
      .nar        (bk_nar[win_b]),
      .par        (bk_par[win_b]),
      .word32     (lk_word32),
      .odd_cfg    (par_odd_cfg),
      .policy     (policy),
      .noncache   (noncache),
      .narrow     (narrow),
      .split_xfer (split_xfer),
      .par_chk    (par_chk),
      .par_odd    (par_odd),
      .attr_err   (attr_err)
   );

   // R8: disabled translation passes the page through as copy-back
   a_r8_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      !xlat_en |-> hit && (ppn_out == lk_vpn) && (policy == 2'b00) && !noncache && !multi_hit);

   // R5: a narrow page is never cached
   a_r5_narrow_nc: assert property (@(posedge clk) disable iff (!rst_n)
      (xlat_en && hit && narrow) |-> noncache);

   // R6: split transfers only for 32-bit accesses to narrow pages
   a_r6_split: assert property (@(posedge clk) disable iff (!rst_n)
      split_xfer |-> (narrow && lk_word32));

   // R4: reserved-policy error only on a translated hit holding 10
   a_r4_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
      attr_err |-> (xlat_en && hit && policy == 2'b10));

   // R12: a multiple match reports a hit
   a_r12_multi_hit: assert property (@(posedge clk) disable iff (!rst_n)
      multi_hit |-> hit);

endmodule

// File: tb/tlb_xlate_tb.sv
`timescale 1ns/1ps
module tlb_xlate_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        xlat_en, lk_valid, lk_word32, par_odd_cfg;
   logic [19:0] lk_vpn;
   logic [7:0]  cur_pid;
   logic        wr_en, wr_bank, wr_way, wr_vld, wr_glb, wr_narrow, wr_par_en;
   logic [3:0]  wr_set;
   logic [15:0] wr_tag;
   logic [7:0]  wr_pid;
   logic [19:0] wr_ppn;
   logic [1:0]  wr_policy;
   logic        hit, multi_hit, hit_bank, hit_way;
   logic [19:0] ppn_out;
   logic [1:0]  policy;
   logic        noncache, narrow, split_xfer, par_chk, par_odd, attr_err;
   logic [1:0]  repl_way;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2 clk = ~clk;

   tlb_xlate u_dut (
      .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .lk_valid(lk_valid),
      .lk_vpn(lk_vpn), .cur_pid(cur_pid), .lk_word32(lk_word32),
      .par_odd_cfg(par_odd_cfg), .wr_en(wr_en), .wr_bank(wr_bank),
      .wr_set(wr_set), .wr_way(wr_way), .wr_tag(wr_tag), .wr_pid(wr_pid),
      .wr_vld(wr_vld), .wr_glb(wr_glb), .wr_ppn(wr_ppn), .wr_policy(wr_policy),
      .wr_narrow(wr_narrow), .wr_par_en(wr_par_en), .hit(hit),
      .multi_hit(multi_hit), .hit_bank(hit_bank), .hit_way(hit_way),
      .ppn_out(ppn_out), .policy(policy), .noncache(noncache), .narrow(narrow),
      .split_xfer(split_xfer), .par_chk(par_chk), .par_odd(par_odd),
      .attr_err(attr_err), .repl_way(repl_way)
   );

   // behavioural reference state
   bit          m_vld [2][16][2];
   int unsigned m_tag [2][16][2];
   int unsigned m_pid [2][16][2];
   bit          m_glb [2][16][2];
   int unsigned m_ppn [2][16][2];
   int unsigned m_pol [2][16][2];
   bit          m_nar [2][16][2];
   bit          m_par [2][16][2];
   bit          m_lru [2][16];

   int unsigned e_ppn, e_pol, e_hb, e_hw, e_cnt;
   bit e_hit, e_multi, e_nc, e_nar, e_split, e_pc, e_po, e_err;
   bit [1:0] e_rep;

   task automatic chk(string req, string what, int unsigned act, int unsigned exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic void model_eval();
      int unsigned s, t;
      s = lk_vpn[3:0];
      t = lk_vpn[19:4];
      e_rep = {m_lru[1][s], m_lru[0][s]};
      e_hit = 0; e_multi = 0; e_ppn = 0; e_pol = 0; e_hb = 0; e_hw = 0; e_cnt = 0;
      e_nc = 0; e_nar = 0; e_split = 0; e_pc = 0; e_po = 0; e_err = 0;
      if (!xlat_en) begin
         e_hit = 1; e_ppn = lk_vpn;
         return;
      end
      for (int b = 0; b < 2; b++)
         for (int w = 0; w < 2; w++)
            if (m_vld[b][s][w] && m_tag[b][s][w] == t &&
                (m_glb[b][s][w] || m_pid[b][s][w] == cur_pid)) begin
               if (e_cnt == 0) begin e_hb = b; e_hw = w; end
               e_cnt++;
            end
      e_hit = (e_cnt > 0);
      e_multi = (e_cnt > 1);
      if (e_hit) begin
         e_ppn   = m_ppn[e_hb][s][e_hw];
         e_pol   = m_pol[e_hb][s][e_hw];
         e_nar   = m_nar[e_hb][s][e_hw];
         e_nc    = (e_pol == 3) || e_nar;
         e_split = e_nar && lk_word32;
         e_pc    = m_par[e_hb][s][e_hw];
         e_po    = e_pc && par_odd_cfg;
         e_err   = (e_pol == 2);
      end
   endfunction

   function automatic void model_update();
      int unsigned s;
      s = lk_vpn[3:0];
      if (lk_valid && xlat_en) begin
         if (e_cnt > 0) m_lru[e_hb][s] = (e_hw == 0);
         else begin
            m_lru[0][s] = !m_lru[0][s];
            m_lru[1][s] = !m_lru[1][s];
         end
      end
      if (wr_en) begin
         m_vld[wr_bank][wr_set][wr_way] = wr_vld;
         m_tag[wr_bank][wr_set][wr_way] = wr_tag;
         m_pid[wr_bank][wr_set][wr_way] = wr_pid;
         m_glb[wr_bank][wr_set][wr_way] = wr_glb;
         m_ppn[wr_bank][wr_set][wr_way] = wr_ppn;
         m_pol[wr_bank][wr_set][wr_way] = wr_policy;
         m_nar[wr_bank][wr_set][wr_way] = wr_narrow;
         m_par[wr_bank][wr_set][wr_way] = wr_par_en;
      end
   endfunction

   // inputs are set at a falling edge; compare, then advance one clock
   task automatic tick();
      #1;
      model_eval();
      chk("R2",  "hit",        hit,        e_hit);
      chk("R2",  "ppn_out",    ppn_out,    e_ppn);
      chk("R2",  "hit_bank",   hit_bank,   e_hb);
      chk("R2",  "hit_way",    hit_way,    e_hw);
      chk("R12", "multi_hit",  multi_hit,  e_multi);
      chk("R4",  "policy",     policy,     e_pol);
      chk("R4",  "attr_err",   attr_err,   e_err);
      chk("R5",  "noncache",   noncache,   e_nc);
      chk("R6",  "narrow",     narrow,     e_nar);
      chk("R6",  "split_xfer", split_xfer, e_split);
      chk("R7",  "par_chk",    par_chk,    e_pc);
      chk("R7",  "par_odd",    par_odd,    e_po);
      chk("R9",  "repl_way",   repl_way,   e_rep);
      @(posedge clk);
      model_update();
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic put(bit bk, int unsigned st, bit wy, int unsigned tg, int unsigned pd,
                      bit gl, int unsigned pp, int unsigned pl, bit nr, bit pr);
      wr_en = 1; wr_bank = bk; wr_set = st[3:0]; wr_way = wy; wr_tag = tg[15:0];
      wr_pid = pd[7:0]; wr_vld = 1; wr_glb = gl; wr_ppn = pp[19:0];
      wr_policy = pl[1:0]; wr_narrow = nr; wr_par_en = pr;
   endtask

   task automatic look(int unsigned tg, int unsigned st, int unsigned pd, bit v);
      lk_vpn = {tg[15:0], st[3:0]}; cur_pid = pd[7:0]; lk_valid = v;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 0; xlat_en = 1; lk_valid = 0; lk_vpn = 0; cur_pid = 0;
      lk_word32 = 0; par_odd_cfg = 0; wr_en = 0; wr_bank = 0; wr_set = 0;
      wr_way = 0; wr_tag = 0; wr_pid = 0; wr_vld = 0; wr_glb = 0; wr_ppn = 0;
      wr_policy = 0; wr_narrow = 0; wr_par_en = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: empty after reset
      look(16'h0012, 5, 8'h07, 1'b0);
      #1;
      chk("R1", "hit after reset", hit, 0);
      chk("R1", "repl_way after reset", repl_way, 0);
      tick();

      // R11: write and same-cycle lookup see the old contents
      look(16'h0012, 5, 8'h07, 1'b1);
      put(0, 5, 0, 16'h0012, 8'h07, 0, 20'hABCDE, 0, 0, 0);
      #1; chk("R11", "hit same cycle as write", hit, 0);
      tick();                               // miss toggles both banks (R10)
      #1; chk("R10", "repl_way after miss", repl_way, 2'b11);
      chk("R11", "hit after write", hit, 1);
      chk("R2", "ppn after write", ppn_out, 20'hABCDE);
      tick();                               // hit bank0 way0 -> bank0 bit 1
      #1; chk("R9", "repl_way after hit", repl_way, 2'b11);

      // R2: wrong PID misses; R3: global entry ignores PID
      look(16'h0012, 5, 8'h08, 1'b0);
      #1; chk("R2", "foreign pid", hit, 0);
      tick();
      put(1, 6, 1, 16'h0100, 8'h01, 1, 20'h11111, 1, 0, 1);
      tick();
      look(16'h0100, 6, 8'hEE, 1'b1); par_odd_cfg = 1;
      #1; chk("R3", "global hit", hit, 1);
      chk("R7", "par_odd", par_odd, 1);
      chk("R9", "repl_way before hit", repl_way, 2'b00);
      tick();
      #1; chk("R9", "bank1 bit after way1 hit", repl_way, 2'b00);

      // R4/R5/R6: reserved policy and narrow override
      put(0, 7, 1, 16'h0200, 8'h03, 0, 20'h22222, 2, 0, 0);
      tick();
      look(16'h0200, 7, 8'h03, 1'b0);
      #1; chk("R4", "attr_err on reserved", attr_err, 1);
      tick();
      put(1, 8, 0, 16'h0300, 8'h03, 0, 20'h33333, 0, 1, 0);
      tick();
      look(16'h0300, 8, 8'h03, 1'b0); lk_word32 = 1;
      #1; chk("R5", "narrow copy-back is noncache", noncache, 1);
      chk("R6", "split 32-bit", split_xfer, 1);
      tick();

      // R13: idle lookups leave replacement bits alone
      look(16'h0999, 9, 8'h03, 1'b0);
      tick(); tick();
      #1; chk("R13", "no update on idle", repl_way, 2'b00);

      // R8: pass-through, no replacement change
      xlat_en = 0; look(16'h0999, 9, 8'h03, 1'b1);
      #1; chk("R8", "pass ppn", ppn_out, {16'h0999, 4'd9});
      tick(); xlat_en = 1; lk_valid = 0;
      #1; chk("R8", "no lru change when off", repl_way, 2'b00);

      // R12: duplicates across banks
      put(1, 10, 0, 16'h0444, 8'h03, 0, 20'h44440, 0, 0, 0); tick();
      put(0, 10, 1, 16'h0444, 8'h03, 1, 20'h44441, 1, 0, 0); tick();
      look(16'h0444, 10, 8'h03, 1'b1);
      #1; chk("R12", "winner ppn", ppn_out, 20'h44441);
      chk("R12", "multi flag", multi_hit, 1);
      tick();

      // mixed traffic against the reference
      for (int i = 0; i < 4000; i++) begin
         int unsigned r;
         r = $urandom;
         xlat_en = (r % 10) != 0;
         lk_valid = r[4];
         lk_word32 = r[5];
         par_odd_cfg = r[6];
         look($urandom % 3, $urandom % 4, (r[7] ? 8'h05 : 8'h09), r[4]);
         if ((r[11:8] % 3) == 0)
            put(r[12], $urandom % 4, r[13], $urandom % 3, (r[14] ? 8'h05 : 8'h09),
                r[15] & r[16], $urandom % 1048576, r[18:17], r[19] & r[20], r[21]);
         tick();
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule